// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date as packed BCD fields in eight byte-wide registers. A free-running base tick (`tick_in`) is divided by a parameterised prescaler. Each time the prescaler completes a second, the block advances seconds, minutes and hours. At midnight it also advances the day of week and the date. The date follows each month's length, including February in leap years. Month then carries into years, and an optional century bit inverts when the years wrap.

A host reaches every byte through a plain register port. It drives `wr_en`, `addr` and `wdata` for a write. It reads `rdata`, which always shows the byte selected by `addr`. There is no handshake and no back-pressure: a write is accepted in the cycle `wr_en` is high, and a read is combinational. A stop flag in the seconds byte freezes timekeeping.

Top module: `ccal_clock_calendar`

## Requirements
- R1: After reset the eight bytes at addresses 0..7 read 00, 00, 00, 01, 01, 01, 00, 00 (in hex).
- R2: Seconds (address 0, bits 6:0) and minutes (address 1, bits 6:0) count in BCD from 00 to 59. Each wraps to 00 and carries one into the next field. The low digit passes from 9 to the next tens value.
- R3: Bit 7 of address 0 is the stop flag. While it is 1, no field advances and the prescaler is held at zero.
- R4: Hours sit in bits 5:0 of address 2 and count in BCD from 00 to 23. Hours wrap to 00 at midnight and carry into day of week and date.
- R5: Bit 7 of address 2 enables the century bit and bit 6 is the century bit. When the enable is 1, the century bit inverts as years wrap from 99 to 00. When the enable is 0, the century bit holds its value.
- R6: Day of week sits in bits 2:0 of address 3 and counts 1 to 7. It returns to 1 at the midnight after 7.
- R7: Date sits in bits 5:0 of address 4 and wraps to 01 after the month's last day. Months 04, 06, 09 and 11 have 30 days. Month 02 has 28 days, or 29 in a leap year. All other months have 31 days.
- R8: A year (address 6, two BCD digits) is a leap year when its value is divisible by 4. Year 00 counts as a leap year.
- R9: Month (address 5, bits 4:0) wraps from 12 to 01 and carries into years. Years wrap from 99 to 00.
- R10: A write is visible on `rdata` from the next cycle. Bits outside a field read 0. Address 7 is a plain 8-bit register that reads back what was written.
- R11: A write to address 0 clears the prescaler. The next advance then comes exactly `TICKS_PER_SEC` base ticks later, and a second that would have completed in the write cycle is dropped.
- R12: When a host write to a field coincides with an advance, the written value wins and no carry leaves that field in that cycle. Fields below the written one still advance.
- R13: One advance happens on the `TICKS_PER_SEC`-th counted base tick, and never earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Base tick, one-cycle pulse, divided down to seconds |
| wr_en | input | 1 | Host write strobe |
| addr | input | 3 | Register select for reads and writes |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Byte selected by `addr` (combinational) |

## Verification
Two functions can land in the same cycle: a host write and the completion of a second. The bench provokes this by raising `tick_in` on the prescaler's final count, together with a write to minutes, while the time reads 05:59:59. It expects 05:10:00, because seconds still wrap while the written minutes block the carry into hours. It then repeats the collision with a write to seconds and expects only the written value, with minutes unchanged.

// File: rtl/ccal_pkg.sv
package ccal_pkg;

  localparam int NREG = 8;
  localparam int AW   = $clog2(NREG);

  typedef enum logic [AW-1:0] {
    REG_SEC  = 3'd0,
    REG_MIN  = 3'd1,
    REG_HOUR = 3'd2,
    REG_DOW  = 3'd3,
    REG_DATE = 3'd4,
    REG_MON  = 3'd5,
    REG_YEAR = 3'd6,
    REG_CTRL = 3'd7
  } ccal_reg_e;

  // Next value of a two-digit BCD number, no range limit applied.
  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_step = {v[7:4] + 4'd1, 4'd0};
    else                bcd_step = v + 8'd1;
  endfunction

endpackage

// File: rtl/ccal_prescaler.sv
module ccal_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic pulse
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt;

  assign pulse = tick & ~clr & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (tick) begin
      if (cnt == LAST)   cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ccal_bcd_field.sv
module ccal_bcd_field #(
  parameter int             W   = 7,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] max_v,
  input  logic [W-1:0] min_v,
  output logic [W-1:0] q,
  output logic         wrap
);
  logic [7:0] q_ext;
  logic [7:0] stepped;
  logic       at_max;

  assign q_ext   = 8'(q);
  assign stepped = ccal_pkg::bcd_step(q_ext);
  assign at_max  = (q == max_v);
  assign wrap    = inc & ~wr & at_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= RST;
    else if (wr)     q <= wdata;
    else if (inc)    q <= at_max ? min_v : stepped[W-1:0];
  end
endmodule

// File: rtl/ccal_month_len.sv
module ccal_month_len (
  input  logic [4:0] month,
  input  logic [2:0] year_bits,  // {tens[0], units[1:0]}
  output logic [5:0] last_day
);
  logic leap;

  // 10*t + u mod 4 == (2*t[0] + u[1:0]) mod 4
  always_comb begin
    logic [1:0] r;
    r    = {year_bits[2], 1'b0} + year_bits[1:0];
    leap = (r == 2'd0);
  end

  always_comb begin
    unique case (month)
      5'h02:                      last_day = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase
  end
endmodule

// File: rtl/ccal_clock_calendar.sv
module ccal_clock_calendar #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_in,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  import ccal_pkg::*;

  logic [NREG-1:0] wsel;
  logic            stop_q, cen_en_q, cen_bit_q;
  logic [7:0]      ctrl_q;
  logic            sec_pulse;

  logic [6:0] sec_q, min_q;
  logic [5:0] hr_q, date_q, last_day;
  logic [2:0] dow_q;
  logic [4:0] mon_q;
  logic [7:0] yr_q;
  logic       sec_wrap, min_wrap, hr_wrap, dow_wrap, date_wrap, mon_wrap, yr_wrap;

  always_comb begin
    wsel = '0;
    if (wr_en) wsel[addr] = 1'b1;
  end

  ccal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick_in),
    .clr(stop_q | wsel[REG_SEC]), .pulse(sec_pulse)
  );

  ccal_month_len u_mlen (
    .month(mon_q), .year_bits({yr_q[4], yr_q[1:0]}), .last_day(last_day)
  );

  ccal_bcd_field #(.W(7), .RST(7'h00)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc(sec_pulse), .wr(wsel[REG_SEC]),
    .wdata(wdata[6:0]), .max_v(7'h59), .min_v(7'h00), .q(sec_q), .wrap(sec_wrap));

  ccal_bcd_field #(.W(7), .RST(7'h00)) u_min (
    .clk(clk), .rst_n(rst_n), .inc(sec_wrap), .wr(wsel[REG_MIN]),
    .wdata(wdata[6:0]), .max_v(7'h59), .min_v(7'h00), .q(min_q), .wrap(min_wrap));

  ccal_bcd_field #(.W(6), .RST(6'h00)) u_hr (
    .clk(clk), .rst_n(rst_n), .inc(min_wrap), .wr(wsel[REG_HOUR]),
    .wdata(wdata[5:0]), .max_v(6'h23), .min_v(6'h00), .q(hr_q), .wrap(hr_wrap));

  ccal_bcd_field #(.W(3), .RST(3'd1)) u_dow (
    .clk(clk), .rst_n(rst_n), .inc(hr_wrap), .wr(wsel[REG_DOW]),
    .wdata(wdata[2:0]), .max_v(3'd7), .min_v(3'd1), .q(dow_q), .wrap(dow_wrap));

  ccal_bcd_field #(.W(6), .RST(6'h01)) u_date (
    .clk(clk), .rst_n(rst_n), .inc(hr_wrap), .wr(wsel[REG_DATE]),
    .wdata(wdata[5:0]), .max_v(last_day), .min_v(6'h01), .q(date_q), .wrap(date_wrap));

  ccal_bcd_field #(.W(5), .RST(5'h01)) u_mon (
    .clk(clk), .rst_n(rst_n), .inc(date_wrap), .wr(wsel[REG_MON]),
    .wdata(wdata[4:0]), .max_v(5'h12), .min_v(5'h01), .q(mon_q), .wrap(mon_wrap));

  ccal_bcd_field #(.W(8), .RST(8'h00)) u_yr (
    .clk(clk), .rst_n(rst_n), .inc(mon_wrap), .wr(wsel[REG_YEAR]),
    .wdata(wdata), .max_v(8'h99), .min_v(8'h00), .q(yr_q), .wrap(yr_wrap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q    <= 1'b0;
      cen_en_q  <= 1'b0;
      cen_bit_q <= 1'b0;
      ctrl_q    <= 8'h00;
    end else begin
      if (wsel[REG_SEC])  stop_q <= wdata[7];
      if (wsel[REG_CTRL]) ctrl_q <= wdata;
      if (wsel[REG_HOUR]) begin
        cen_en_q  <= wdata[7];
        cen_bit_q <= wdata[6];
      end else if (yr_wrap && cen_en_q) begin
        cen_bit_q <= ~cen_bit_q;
      end
    end
  end

  always_comb begin
    unique case (ccal_reg_e'(addr))
      REG_SEC:  rdata = {stop_q, sec_q};
      REG_MIN:  rdata = {1'b0, min_q};
      REG_HOUR: rdata = {cen_en_q, cen_bit_q, hr_q};
      REG_DOW:  rdata = {5'b0, dow_q};
      REG_DATE: rdata = {2'b0, date_q};
      REG_MON:  rdata = {3'b0, mon_q};
      REG_YEAR: rdata = yr_q;
      default:  rdata = ctrl_q;
    endcase
  end
endmodule

// File: rtl/ccal_checker.sv
module ccal_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       stop,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       sec_pulse,
  input logic [6:0] sec,
  input logic [6:0] min,
  input logic       cen_en,
  input logic       cen_bit,
  input logic [2:0] dow,
  input logic       dow_wrap,
  input logic       yr_wrap
);
  AST_STOP_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !sec_pulse); // R3

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && sec == 7'h59 && !(wr_en && wr_addr == 3'd0)) |=> sec == 7'h00); // R2

  AST_CENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_en && !(wr_en && wr_addr == 3'd2)) |=> $stable(cen_bit)); // R5

  AST_CENT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (yr_wrap && cen_en && !(wr_en && wr_addr == 3'd2)) |=> cen_bit != $past(cen_bit)); // R5

  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    dow_wrap |=> dow == 3'd1); // R6

  AST_MIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd1) |=> min == $past(wr_data[6:0])); // R10
endmodule

bind ccal_clock_calendar ccal_checker u_chk (
  .clk(clk), .rst_n(rst_n), .stop(stop_q), .wr_en(wr_en), .wr_addr(addr),
  .wr_data(wdata), .sec_pulse(sec_pulse), .sec(sec_q), .min(min_q),
  .cen_en(cen_en_q), .cen_bit(cen_bit_q), .dow(dow_q), .dow_wrap(dow_wrap),
  .yr_wrap(yr_wrap)
);

// File: tb/tb_ccal_clock_calendar.sv
module tb_ccal_clock_calendar;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  ccal_clock_calendar #(.TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
    end
  endtask

  task automatic tick_with_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); tick_in = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); tick_in = 1'b0; wr_en = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    n_checks++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s addr %0d: got %h expected %h", req, a, rdata, exp);
    end
  endtask

  // Loads all fields, seconds last so the prescaler starts aligned.
  task automatic set_time(input logic [7:0] yr, mo, dt, dw, hr, mi, se);
    wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, dt); wr(3'd3, dw);
    wr(3'd2, hr); wr(3'd1, mi); wr(3'd0, se);
  endtask

  task automatic t_reset;
    expect_reg("R1", 3'd0, 8'h00); expect_reg("R1", 3'd1, 8'h00);
    expect_reg("R1", 3'd2, 8'h00); expect_reg("R1", 3'd3, 8'h01);
    expect_reg("R1", 3'd4, 8'h01); expect_reg("R1", 3'd5, 8'h01);
    expect_reg("R1", 3'd6, 8'h00); expect_reg("R1", 3'd7, 8'h00);
  endtask

  task automatic t_seconds;
    set_time(8'h20, 8'h06, 8'h10, 8'h2, 8'h12, 8'h34, 8'h09);
    ticks(TPS); expect_reg("R2 digit carry", 3'd0, 8'h10);
    wr(3'd0, 8'h58);
    ticks(TPS); expect_reg("R2", 3'd0, 8'h59);
    ticks(TPS); expect_reg("R2 wrap", 3'd0, 8'h00);
    expect_reg("R2 carry", 3'd1, 8'h35);
    expect_reg("R2 hours hold", 3'd2, 8'h12);
  endtask

  task automatic t_midnight;
    set_time(8'h21, 8'h03, 8'h15, 8'h7, 8'h23, 8'h59, 8'h59);
    ticks(TPS);
    expect_reg("R4", 3'd2, 8'h00); expect_reg("R4", 3'd1, 8'h00);
    expect_reg("R6", 3'd3, 8'h01); expect_reg("R4 date", 3'd4, 8'h16);
  endtask

  task automatic t_month_len;
    set_time(8'h21, 8'h04, 8'h30, 8'h1, 8'h23, 8'h59, 8'h59);
    ticks(TPS);
    expect_reg("R7 30-day", 3'd4, 8'h01); expect_reg("R7 30-day", 3'd5, 8'h05);
    set_time(8'h21, 8'h01, 8'h30, 8'h1, 8'h23, 8'h59, 8'h59);
    ticks(TPS);
    expect_reg("R7 31-day", 3'd4, 8'h31); expect_reg("R7 31-day", 3'd5, 8'h01);
  endtask

  task automatic feb_case(input string req, input logic [7:0] yr,
                          input logic [7:0] exp_date, input logic [7:0] exp_mon);
    set_time(yr, 8'h02, 8'h28, 8'h1, 8'h23, 8'h59, 8'h59);
    ticks(TPS);
    expect_reg(req, 3'd4, exp_date); expect_reg(req, 3'd5, exp_mon);
  endtask

  task automatic t_leap;
    feb_case("R8 year 24", 8'h24, 8'h29, 8'h02);
    feb_case("R8 year 23", 8'h23, 8'h01, 8'h03);
    feb_case("R8 year 00", 8'h00, 8'h29, 8'h02);
    feb_case("R8 year 10", 8'h10, 8'h01, 8'h03);
    feb_case("R8 year 12", 8'h12, 8'h29, 8'h02);
    set_time(8'h24, 8'h02, 8'h29, 8'h1, 8'h23, 8'h59, 8'h59);
    ticks(TPS);
    expect_reg("R7 leap end", 3'd4, 8'h01); expect_reg("R7 leap end", 3'd5, 8'h03);
  endtask

  task automatic t_century;
    set_time(8'h99, 8'h12, 8'h31, 8'h3, 8'hE3, 8'h59, 8'h59);
    ticks(TPS);
    expect_reg("R9 year", 3'd6, 8'h00); expect_reg("R9 month", 3'd5, 8'h01);
    expect_reg("R7 date", 3'd4, 8'h01); expect_reg("R5 toggle", 3'd2, 8'h80);
    expect_reg("R6 step", 3'd3, 8'h04);
    set_time(8'h99, 8'h12, 8'h31, 8'h3, 8'h63, 8'h59, 8'h59);
    ticks(TPS);
    expect_reg("R5 hold", 3'd2, 8'h40); expect_reg("R9 year", 3'd6, 8'h00);
  endtask

  task automatic t_stop;
    set_time(8'h21, 8'h05, 8'h05, 8'h1, 8'h08, 8'h00, 8'h90);
    ticks(3 * TPS);
    expect_reg("R3 frozen", 3'd0, 8'h90);
    expect_reg("R3 frozen", 3'd1, 8'h00);
    wr(3'd0, 8'h10);
    ticks(TPS - 1); expect_reg("R13 early", 3'd0, 8'h10);
    ticks(1);       expect_reg("R13 on count", 3'd0, 8'h11);
  endtask

  task automatic t_sec_clear;
    wr(3'd0, 8'h20);
    ticks(2);
    wr(3'd0, 8'h30);
    ticks(TPS - 1); expect_reg("R11 cleared", 3'd0, 8'h30);
    ticks(1);       expect_reg("R11 full second", 3'd0, 8'h31);
  endtask

  task automatic t_collision;
    set_time(8'h21, 8'h05, 8'h05, 8'h1, 8'h05, 8'h59, 8'h59);
    ticks(TPS - 1);
    tick_with_write(3'd1, 8'h10);
    expect_reg("R12 sec", 3'd0, 8'h00); expect_reg("R12 min", 3'd1, 8'h10);
    expect_reg("R12 hour", 3'd2, 8'h05);
    set_time(8'h21, 8'h05, 8'h05, 8'h1, 8'h05, 8'h20, 8'h59);
    ticks(TPS - 1);
    tick_with_write(3'd0, 8'h05);
    expect_reg("R11 dropped", 3'd0, 8'h05); expect_reg("R11 dropped", 3'd1, 8'h20);
  endtask

  task automatic t_fields;
    wr(3'd1, 8'hB4); expect_reg("R10 min", 3'd1, 8'h34);
    wr(3'd3, 8'hFD); expect_reg("R10 dow", 3'd3, 8'h05);
    wr(3'd5, 8'hE9); expect_reg("R10 month", 3'd5, 8'h09);
    wr(3'd7, 8'hA5); expect_reg("R10 ctrl", 3'd7, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_seconds();
    t_midnight();
    t_month_len();
    t_leap();
    t_century();
    t_stop();
    t_sec_clear();
    t_collision();
    t_fields();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule